// File: doc/BRIEF.md
# Cache Access Policy Controller

This block settles the outcome of one data-cache access once the tag lookup has answered. It takes the lookup verdict (hit, miss, could-not-reserve, or an unrecognised code), the access kind (read or write, atomic or not, global or local address space), the victim line's dirty bit, the miss-tracking table's state for the block, and the current occupancy of the outbound miss queue. From these it produces a final status, the line-state updates the tag array should apply, and up to three ordered requests for the miss queue.

The write-hit policy and the write-allocate choice come from static configuration pins that are held stable during operation. Before any handler commits, the controller reserves queue room for the worst case of that handler's path, so an accepted access can never overflow the miss queue. An access that cannot be accepted leaves every piece of cache state untouched, and the requester retries it later. All results are registered and appear one clock after the access is presented.

Top module: `cache_policy_ctrl`

## Requirements
- R1: With a legal configuration, a lookup verdict of could-not-reserve (`probe_st`=2) returns status could-not-reserve (`res_status`=2), with no line update and no request.
- R2: A lookup verdict code of 3, or a `cfg_wr_hit` value outside 2..5 (0 unset, 1 read-only, 6 and 7 undefined), raises `res_fault`. The status is then 2, with no line update and no request.
- R3: A read hit (`probe_st`=0) returns status hit (0) and refreshes recency (`res_touch`). It also marks the line modified (`res_mark_mod`) exactly when the access is atomic. It issues no request.
- R4: A read miss (`probe_st`=1) is accepted only when at least 2 queue slots are free and `mshr_full` is low; otherwise it returns status 2. When accepted it returns miss (1) and pushes a fill read, but only if the block has no entry yet (`mshr_hit` low); a merge pushes nothing.
- R5: An accepted read miss that allocates a new entry also pushes a write-back when the victim is dirty and the write-hit policy is not write-through.
- R6: A write hit under write-back policy (`cfg_wr_hit`=2) returns hit, refreshes recency, marks the line modified and issues no request.
- R7: A write hit under write-through (`cfg_wr_hit`=3) needs 1 free slot. It then returns hit, refreshes recency and forwards the write; otherwise it returns 2.
- R8: A write hit under write-evict (`cfg_wr_hit`=4) needs 1 free slot. It then returns hit, invalidates the line (`res_inval`) and forwards the write; otherwise it returns 2.
- R9: Under the hybrid policy (`cfg_wr_hit`=5), a write hit to global space (`acc_global`=1) behaves as in R8, and one to local space behaves as in R6.
- R10: A write miss without allocation (`cfg_wr_alloc`=0) needs 1 free slot. It then forwards the write and returns miss; otherwise it returns 2.
- R11: A write miss with allocation (`cfg_wr_alloc`=1) needs 3 free slots and `mshr_full` low, otherwise it returns 2. When accepted it returns miss and forwards the write. A fill read and the R5 write-back follow, under the same conditions as for a read miss.
- R12: Requests fill slots from slot 0 upward with no gaps, in the order write, fill, write-back. Slot s has valid bit `req_vld[s]` and kind `req_kind[2s+1:2s]`, where kind 0 is write, 1 is fill and 2 is write-back. An unused slot carries kind 0.
- R13: Results appear in the cycle after `acc_valid` is sampled high. In any other cycle, and during reset, `res_valid`, all line updates, `res_fault` and all request valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_atomic | input | 1 | Atomic access flag |
| acc_global | input | 1 | 1 = global space, 0 = local space |
| probe_st | input | 2 | Lookup verdict: 0 hit, 1 miss, 2 could-not-reserve, 3 unknown |
| victim_dirty | input | 1 | Line chosen for eviction holds modified data |
| mshr_hit | input | 1 | Block already has a miss-tracking entry |
| mshr_full | input | 1 | No entry or merge room for this block |
| mq_count | input | CNT_W | Entries now in the miss queue |
| cfg_wr_hit | input | 3 | Static write-hit policy code |
| cfg_wr_alloc | input | 1 | Static write-allocate enable |
| res_valid | output | 1 | Result valid |
| res_status | output | 2 | Final status: 0 hit, 1 miss, 2 could-not-reserve |
| res_touch | output | 1 | Refresh recency of the line |
| res_mark_mod | output | 1 | Mark the line modified |
| res_inval | output | 1 | Invalidate the line |
| res_fault | output | 1 | Unknown verdict or illegal configuration |
| req_vld | output | 3 | Per-slot request valid |
| req_kind | output | 6 | Per-slot request kind, 2 bits each |

## Verification
The bench builds the controller with a miss queue of depth 4, so the occupancy input can reach every threshold the handlers use (1, 2 and 3 free slots), as well as a completely full queue. This brings the accept/refuse edge of each path within a single step of occupancy, and lets the three-request write-allocate case fill a slot pattern of 111 from one free margin. The configuration pins are changed between directed scenarios, so that every write-hit policy, both allocate choices and the illegal codes are covered with the same instance.

// File: rtl/cpc_pkg.sv
// Package: shared encodings and room thresholds for the cache policy controller.
// Assumes a fixed set of three request kinds and two-bit status codes.
package cpc_pkg;
    typedef enum logic [1:0] {PRB_HIT = 2'd0, PRB_MISS = 2'd1, PRB_RSV = 2'd2, PRB_BAD = 2'd3} probe_e;
    typedef enum logic [1:0] {ST_HIT = 2'd0, ST_MISS = 2'd1, ST_RSV = 2'd2} status_e;
    typedef enum logic [2:0] {
        WH_UNSET = 3'd0, WH_RDONLY = 3'd1, WH_WBACK = 3'd2,
        WH_WTHRU = 3'd3, WH_WEVICT = 3'd4, WH_HYBRID = 3'd5
    } wr_hit_e;
    typedef enum logic [1:0] {RQ_WRITE = 2'd0, RQ_FILL = 2'd1, RQ_WBACK = 2'd2} req_e;

    localparam int NSLOT   = 3;   // most requests one access can emit
    localparam int ROOM_WR = 1;   // write forward alone
    localparam int ROOM_RD = 2;   // fill plus possible write-back
    localparam int ROOM_WA = 3;   // write, fill and write-back
endpackage

// File: rtl/cpc_room_check.sv
// Module: computes free miss-queue slots and whether each handler's
// worst-case room is available. Assumes a count above depth means no room.
module cpc_room_check #(
    parameter int MQ_DEPTH = 8,
    parameter int CNT_W    = $clog2(MQ_DEPTH + 1)
) (
    input  logic [CNT_W-1:0] mq_count,
    output logic             room_wr,
    output logic             room_rd,
    output logic             room_wa
);
    import cpc_pkg::*;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(MQ_DEPTH);

    logic [CNT_W-1:0] free_slots;

    // Purpose: saturating free-slot count.
    always_comb begin
        free_slots = (mq_count >= DEPTH_C) ? '0 : DEPTH_C - mq_count;
    end

    assign room_wr = free_slots >= CNT_W'(ROOM_WR);
    assign room_rd = free_slots >= CNT_W'(ROOM_RD);
    assign room_wa = free_slots >= CNT_W'(ROOM_WA);
endmodule

// File: rtl/cpc_decide.sv
// Module: combinational policy decision for one access. Produces status,
// line updates, a fault flag and the set of wanted requests (unordered).
// Assumes configuration pins are static and room flags are precomputed.
module cpc_decide (
    input  logic       acc_write,
    input  logic       acc_atomic,
    input  logic       acc_global,
    input  logic [1:0] probe_st,
    input  logic       victim_dirty,
    input  logic       mshr_hit,
    input  logic       mshr_full,
    input  logic [2:0] cfg_wr_hit,
    input  logic       cfg_wr_alloc,
    input  logic       room_wr,
    input  logic       room_rd,
    input  logic       room_wa,
    output logic [1:0] d_status,
    output logic       d_touch,
    output logic       d_mark_mod,
    output logic       d_inval,
    output logic       d_fault,
    output logic [2:0] d_want
);
    import cpc_pkg::*;

    probe_e  prb;
    wr_hit_e pol;
    logic    cfg_ok, is_wt, evict_now, thru_now, wb_victim;

    assign prb       = probe_e'(probe_st);
    assign pol       = wr_hit_e'(cfg_wr_hit);
    assign cfg_ok    = (pol == WH_WBACK) || (pol == WH_WTHRU) || (pol == WH_WEVICT) || (pol == WH_HYBRID);
    assign is_wt     = (pol == WH_WTHRU);
    assign evict_now = (pol == WH_WEVICT) || ((pol == WH_HYBRID) && acc_global);
    assign thru_now  = is_wt;
    assign wb_victim = !mshr_hit && victim_dirty && !is_wt;

    // Purpose: select the handler for this verdict and access kind.
    always_comb begin
        d_status   = ST_RSV;
        d_touch    = 1'b0;
        d_mark_mod = 1'b0;
        d_inval    = 1'b0;
        d_fault    = 1'b0;
        d_want     = '0;
        if (prb == PRB_BAD || !cfg_ok) begin
            d_fault = 1'b1;
        end else if (prb == PRB_HIT && !acc_write) begin
            d_status   = ST_HIT;
            d_touch    = 1'b1;
            d_mark_mod = acc_atomic;
        end else if (prb == PRB_HIT) begin
            if (evict_now) begin
                if (room_wr) begin
                    d_status         = ST_HIT;
                    d_inval          = 1'b1;
                    d_want[RQ_WRITE] = 1'b1;
                end
            end else if (thru_now) begin
                if (room_wr) begin
                    d_status         = ST_HIT;
                    d_touch          = 1'b1;
                    d_want[RQ_WRITE] = 1'b1;
                end
            end else begin
                d_status   = ST_HIT;
                d_touch    = 1'b1;
                d_mark_mod = 1'b1;
            end
        end else if (prb == PRB_MISS && !acc_write) begin
            if (room_rd && !mshr_full) begin
                d_status         = ST_MISS;
                d_want[RQ_FILL]  = !mshr_hit;
                d_want[RQ_WBACK] = wb_victim;
            end
        end else if (prb == PRB_MISS && !cfg_wr_alloc) begin
            if (room_wr) begin
                d_status         = ST_MISS;
                d_want[RQ_WRITE] = 1'b1;
            end
        end else if (prb == PRB_MISS) begin
            if (room_wa && !mshr_full) begin
                d_status         = ST_MISS;
                d_want[RQ_WRITE] = 1'b1;
                d_want[RQ_FILL]  = !mshr_hit;
                d_want[RQ_WBACK] = wb_victim;
            end
        end
    end
endmodule

// File: rtl/cpc_req_pack.sv
// Module: packs the wanted request set into contiguous slots, lowest
// kind code first. Assumes want bit k means request kind k.
module cpc_req_pack #(
    parameter int NS = 3
) (
    input  logic [NS-1:0]   want,
    output logic [NS-1:0]   vld,
    output logic [2*NS-1:0] kind
);
    for (genvar s = 0; s < NS; s++) begin : g_slot
        logic       v;
        logic [1:0] kd;
        // Purpose: slot s takes the s-th set bit of want.
        always_comb begin
            automatic int seen = 0;
            v  = 1'b0;
            kd = 2'd0;
            for (int k = 0; k < NS; k++) begin
                if (want[k]) begin
                    if (seen == s) begin
                        v  = 1'b1;
                        kd = 2'(k);
                    end
                    seen = seen + 1;
                end
            end
        end
        assign vld[s]         = v;
        assign kind[2*s +: 2] = kd;
    end
endmodule

// File: rtl/cache_policy_ctrl.sv
// Module: top of the cache policy controller. Registers the decision for a
// presented access; outputs are quiet when no access was presented.
// Assumes cfg_* pins are static and mq_count reflects the queue this cycle.
module cache_policy_ctrl #(
    parameter int MQ_DEPTH = 8,
    parameter int CNT_W    = $clog2(MQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_atomic,
    input  logic             acc_global,
    input  logic [1:0]       probe_st,
    input  logic             victim_dirty,
    input  logic             mshr_hit,
    input  logic             mshr_full,
    input  logic [CNT_W-1:0] mq_count,
    input  logic [2:0]       cfg_wr_hit,
    input  logic             cfg_wr_alloc,
    output logic             res_valid,
    output logic [1:0]       res_status,
    output logic             res_touch,
    output logic             res_mark_mod,
    output logic             res_inval,
    output logic             res_fault,
    output logic [2:0]       req_vld,
    output logic [5:0]       req_kind
);
    import cpc_pkg::*;

    logic room_wr, room_rd, room_wa;
    logic [1:0] d_status;
    logic d_touch, d_mark_mod, d_inval, d_fault;
    logic [NSLOT-1:0]   d_want, p_vld;
    logic [2*NSLOT-1:0] p_kind;

    cpc_room_check #(.MQ_DEPTH(MQ_DEPTH), .CNT_W(CNT_W)) u_room (
        .mq_count(mq_count), .room_wr(room_wr), .room_rd(room_rd), .room_wa(room_wa)
    );

    cpc_decide u_dec (
        .acc_write(acc_write), .acc_atomic(acc_atomic), .acc_global(acc_global),
        .probe_st(probe_st), .victim_dirty(victim_dirty), .mshr_hit(mshr_hit),
        .mshr_full(mshr_full), .cfg_wr_hit(cfg_wr_hit), .cfg_wr_alloc(cfg_wr_alloc),
        .room_wr(room_wr), .room_rd(room_rd), .room_wa(room_wa),
        .d_status(d_status), .d_touch(d_touch), .d_mark_mod(d_mark_mod),
        .d_inval(d_inval), .d_fault(d_fault), .d_want(d_want)
    );

    cpc_req_pack #(.NS(NSLOT)) u_pack (.want(d_want), .vld(p_vld), .kind(p_kind));

    // Purpose: capture the decision for a presented access, else stay quiet.
    always_ff @(posedge clk) begin
        if (!rst_n || !acc_valid) begin
            res_valid    <= 1'b0;
            res_status   <= ST_HIT;
            res_touch    <= 1'b0;
            res_mark_mod <= 1'b0;
            res_inval    <= 1'b0;
            res_fault    <= 1'b0;
            req_vld      <= '0;
            req_kind     <= '0;
        end else begin
            res_valid    <= 1'b1;
            res_status   <= d_status;
            res_touch    <= d_touch;
            res_mark_mod <= d_mark_mod;
            res_inval    <= d_inval;
            res_fault    <= d_fault;
            req_vld      <= p_vld;
            req_kind     <= p_kind;
        end
    end
endmodule

// File: rtl/cpc_checker.sv
// Module: property checker for cache_policy_ctrl, attached with bind.
// Assumes the top's port names and parameters.
module cpc_checker #(
    parameter int MQ_DEPTH = 8,
    parameter int CNT_W    = $clog2(MQ_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [1:0]       probe_st,
    input logic [CNT_W-1:0] mq_count,
    input logic [2:0]       cfg_wr_hit,
    input logic             res_valid,
    input logic [1:0]       res_status,
    input logic             res_touch,
    input logic             res_mark_mod,
    input logic             res_inval,
    input logic             res_fault,
    input logic [2:0]       req_vld
);
    logic [CNT_W:0] room_left;
    logic           legal_cfg;
    assign room_left = (mq_count >= CNT_W'(MQ_DEPTH)) ? '0 : (CNT_W+1)'(MQ_DEPTH) - (CNT_W+1)'(mq_count);
    assign legal_cfg = (cfg_wr_hit >= 3'd2) && (cfg_wr_hit <= 3'd5);

    a_r1_rsv_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && probe_st == 2'd2 && legal_cfg |=> res_status == 2'd2 && req_vld == 3'd0
            && !res_touch && !res_mark_mod && !res_inval);

    a_r2_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_status == 2'd2 && req_vld == 3'd0 && !res_touch && !res_mark_mod && !res_inval);

    a_r3_read_hit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && probe_st == 2'd0 && legal_cfg |=> res_status == 2'd0 && req_vld == 3'd0);

    a_r11_within_room: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> $countones(req_vld) <= $past(room_left));

    a_r12_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld == 3'd0 || req_vld == 3'd1 || req_vld == 3'd3 || req_vld == 3'd7);

    a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid && req_vld == 3'd0 && !res_fault);

    a_r8_evict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        res_inval |-> !res_mark_mod && !res_touch);
endmodule

bind cache_policy_ctrl cpc_checker #(.MQ_DEPTH(MQ_DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cache_policy_ctrl.sv
module sim_cache_policy_ctrl;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_atomic = 1'b0, acc_global = 1'b0;
    logic [1:0] probe_st = 2'd0;
    logic victim_dirty = 1'b0, mshr_hit = 1'b0, mshr_full = 1'b0;
    logic [CW-1:0] mq_count = '0;
    logic [2:0] cfg_wr_hit = 3'd2;
    logic cfg_wr_alloc = 1'b0;
    logic res_valid, res_touch, res_mark_mod, res_inval, res_fault;
    logic [1:0] res_status;
    logic [2:0] req_vld;
    logic [5:0] req_kind;

    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cache_policy_ctrl #(.MQ_DEPTH(DEPTH)) u0 (.*);

    task automatic access(input logic w, at, gl, input logic [1:0] pr, input logic dirty, mh, mf,
                          input int cnt, input logic [2:0] cfg, input logic alloc);
        @(negedge clk);
        acc_write = w; acc_atomic = at; acc_global = gl; probe_st = pr;
        victim_dirty = dirty; mshr_hit = mh; mshr_full = mf; mq_count = CW'(cnt);
        cfg_wr_hit = cfg; cfg_wr_alloc = alloc; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [1:0] st, input logic tch, md, inv, flt,
                              input logic [2:0] vld, input logic [5:0] knd);
        logic [14:0] got, exp;
        got = {res_valid, res_status, res_touch, res_mark_mod, res_inval, res_fault, req_vld, req_kind};
        exp = {1'b1, st, tch, md, inv, flt, vld, knd};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual={v,st,touch,mod,inv,flt,vld,kind}=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic expect_quiet(input string req);
        checks++;
        if (res_valid !== 1'b0 || req_vld !== 3'd0 || res_fault !== 1'b0 || res_touch !== 1'b0) begin
            failures++;
            $display("FAIL %s actual valid=%b vld=%b expected valid=0 vld=000", req, res_valid, req_vld);
        end
    endtask

    task automatic t_reset;  // R13
        acc_valid = 1'b1;
        repeat (3) @(negedge clk);
        expect_quiet("R13 reset");
        acc_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        expect_quiet("R13 after reset idle");
    endtask

    task automatic t_rsv_and_fault;  // R1 R2
        access(1, 0, 1, 2'd2, 1, 0, 0, 0, 3'd2, 1);
        expect_out("R1 rsv passthru", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(0, 0, 0, 2'd3, 0, 0, 0, 0, 3'd2, 0);
        expect_out("R2 unknown verdict", 2'd2, 0, 0, 0, 1, 3'b000, 6'h00);
        access(0, 0, 0, 2'd0, 0, 0, 0, 0, 3'd1, 0);
        expect_out("R2 read-only cfg", 2'd2, 0, 0, 0, 1, 3'b000, 6'h00);
        access(1, 0, 0, 2'd1, 0, 0, 0, 0, 3'd0, 1);
        expect_out("R2 unset cfg", 2'd2, 0, 0, 0, 1, 3'b000, 6'h00);
    endtask

    task automatic t_read_hit;  // R3
        access(0, 0, 1, 2'd0, 1, 0, 0, 4, 3'd2, 0);
        expect_out("R3 read hit", 2'd0, 1, 0, 0, 0, 3'b000, 6'h00);
        access(0, 1, 1, 2'd0, 0, 0, 0, 4, 3'd4, 0);
        expect_out("R3 atomic read hit", 2'd0, 1, 1, 0, 0, 3'b000, 6'h00);
    endtask

    task automatic t_read_miss;  // R4 R5
        access(0, 0, 1, 2'd1, 0, 0, 0, 2, 3'd2, 0);
        expect_out("R4 read miss fill", 2'd1, 0, 0, 0, 0, 3'b001, 6'h01);
        access(0, 0, 1, 2'd1, 0, 0, 0, 3, 3'd2, 0);
        expect_out("R4 read miss no room", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(0, 0, 1, 2'd1, 0, 1, 1, 0, 3'd2, 0);
        expect_out("R4 read miss table full", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(0, 0, 1, 2'd1, 1, 1, 0, 0, 3'd2, 0);
        expect_out("R4 read miss merge", 2'd1, 0, 0, 0, 0, 3'b000, 6'h00);
        access(0, 0, 1, 2'd1, 1, 0, 0, 2, 3'd2, 0);
        expect_out("R5 dirty victim write-back", 2'd1, 0, 0, 0, 0, 3'b011, 6'h09);
        access(0, 0, 1, 2'd1, 1, 0, 0, 2, 3'd3, 0);
        expect_out("R5 write-through no write-back", 2'd1, 0, 0, 0, 0, 3'b001, 6'h01);
    endtask

    task automatic t_write_hit;  // R6 R7 R8 R9
        access(1, 0, 1, 2'd0, 0, 0, 0, 4, 3'd2, 0);
        expect_out("R6 write-back hit", 2'd0, 1, 1, 0, 0, 3'b000, 6'h00);
        access(1, 0, 1, 2'd0, 0, 0, 0, 3, 3'd3, 0);
        expect_out("R7 write-through hit", 2'd0, 1, 0, 0, 0, 3'b001, 6'h00);
        access(1, 0, 1, 2'd0, 0, 0, 0, 4, 3'd3, 0);
        expect_out("R7 write-through full", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(1, 0, 0, 2'd0, 0, 0, 0, 3, 3'd4, 0);
        expect_out("R8 write-evict hit", 2'd0, 0, 0, 1, 0, 3'b001, 6'h00);
        access(1, 0, 0, 2'd0, 0, 0, 0, 4, 3'd4, 0);
        expect_out("R8 write-evict full", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(1, 0, 1, 2'd0, 0, 0, 0, 3, 3'd5, 0);
        expect_out("R9 hybrid global", 2'd0, 0, 0, 1, 0, 3'b001, 6'h00);
        access(1, 0, 0, 2'd0, 0, 0, 0, 4, 3'd5, 0);
        expect_out("R9 hybrid local", 2'd0, 1, 1, 0, 0, 3'b000, 6'h00);
    endtask

    task automatic t_write_miss;  // R10 R11 R12
        access(1, 0, 1, 2'd1, 1, 0, 0, 3, 3'd2, 0);
        expect_out("R10 no-allocate miss", 2'd1, 0, 0, 0, 0, 3'b001, 6'h00);
        access(1, 0, 1, 2'd1, 0, 0, 0, 4, 3'd2, 0);
        expect_out("R10 no-allocate full", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(1, 0, 1, 2'd1, 1, 0, 0, 1, 3'd2, 1);
        expect_out("R11 R12 allocate three requests", 2'd1, 0, 0, 0, 0, 3'b111, 6'h24);
        access(1, 0, 1, 2'd1, 0, 0, 0, 2, 3'd2, 1);
        expect_out("R11 allocate short room", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(1, 0, 1, 2'd1, 0, 0, 1, 0, 3'd2, 1);
        expect_out("R11 allocate table full", 2'd2, 0, 0, 0, 0, 3'b000, 6'h00);
        access(1, 0, 1, 2'd1, 1, 1, 0, 0, 3'd2, 1);
        expect_out("R11 allocate merge", 2'd1, 0, 0, 0, 0, 3'b001, 6'h00);
        access(1, 0, 1, 2'd1, 1, 0, 0, 1, 3'd3, 1);
        expect_out("R12 write then fill", 2'd1, 0, 0, 0, 0, 3'b011, 6'h04);
        @(negedge clk);
        expect_quiet("R13 idle after access");
    endtask

    initial begin
        t_reset();
        t_rsv_and_fault();
        t_read_hit();
        t_read_miss();
        t_write_hit();
        t_write_miss();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R13 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule